// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block holds the digital timing and counting for a dual-slope integrating analog-to-digital converter. Each conversion frame has a fixed length. It opens with a zeroing phase, then integrates the unknown input for an exact number of clocks, then integrates a reference of opposite sign. The external integrator comparator ends that last phase when the integrator output crosses zero. The sequencer drives one enable per phase and the reference-sign select. It reports the de-integrate clock count as the magnitude of the reading, and the captured polarity as its sign.

The polarity is taken from the current conversion. The input-polarity comparator is sampled on the last clock of the integrate window. That sample picks the reference sign used for de-integration, and the same value is reported as the sign of the result. If no zero crossing arrives within the de-integrate limit, the reading saturates and is flagged over-range. Whatever time the de-integrate phase leaves unused is idle time before the next frame, so readings come at a constant rate.

The phase lengths are parameters. The defaults are 10,000 clocks of zeroing, a 10,000-clock integrate window (1,000 suits the shorter-range variant), a de-integrate limit of 20,000 clocks and a 40,000-clock frame.

Top module: `dsc_sequencer`

## Requirements
- R1: The phases run in the order zeroing, integrate, de-integrate, idle. Each has its enable (`az_en_o`, `int_en_o`, `deint_en_o`). At most one enable is high, and none is high in idle.
- R2: Zeroing is active for the first AZ_LEN clocks of every frame, frame cycles 0 to AZ_LEN-1.
- R3: Integrate is active for exactly INT_LEN clocks, frame cycles AZ_LEN to AZ_LEN+INT_LEN-1, whatever the comparator inputs do.
- R4: `pol_i` (1 = negative input) is sampled only on the last integrate clock. For the whole de-integrate phase, `ref_pos_o` equals that sample (1 = positive reference selected). `pol_i` at any other time has no effect.
- R5: If `zc_i` is high on de-integrate clock k (k = 0 for the first), the phase ends after that clock and the result is count k with `ovr_o` = 0.
- R6: If `zc_i` stays low for all DEINT_MAX de-integrate clocks, the phase ends and the result is count DEINT_MAX with `ovr_o` = 1.
- R7: `count_o`, `sign_o` and `ovr_o` update together on the clock after the deciding de-integrate clock. `valid_o` is high for exactly that one clock. The three outputs then hold until the next result. `sign_o` equals the polarity captured in the same frame.
- R8: The frame is always FRAME_LEN clocks. Zeroing restarts at frame cycle FRAME_LEN, however early the zero crossing came.
- R9: `zc_i` has no effect outside the de-integrate phase: no strobe, no change of result, no change of phase timing.
- R10: While `rst_ni` is low, zeroing is enabled and the other enables are low. `valid_o`, `count_o`, `sign_o` and `ovr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zc_i | input | 1 | Integrator zero-crossing comparator, 1 = crossed |
| pol_i | input | 1 | Input polarity comparator, 1 = negative input |
| az_en_o | output | 1 | Zeroing phase switch enable |
| int_en_o | output | 1 | Signal integrate switch enable |
| deint_en_o | output | 1 | Reference de-integrate switch enable |
| ref_pos_o | output | 1 | Reference sign select, 1 = positive reference |
| count_o | output | CNT_W = $clog2(DEINT_MAX+1) | Latched magnitude count |
| sign_o | output | 1 | Latched sign, 1 = negative |
| ovr_o | output | 1 | Latched over-range flag |
| valid_o | output | 1 | One-clock strobe for a new result |

## Verification
The assertions assume FRAME_LEN is at least AZ_LEN+INT_LEN+DEINT_MAX. With that, de-integration always ends inside its own frame, and the result strobe never coincides with a wrap to zeroing. The bench uses parameters that satisfy this, with idle time to spare. In each frame the bench holds `zc_i` low on every de-integrate clock before the chosen crossing clock, because the comparator can report a crossing only once per phase. It also holds `pol_i` at the chosen polarity on the sampling clock. Outside those windows both inputs carry random values, which checks that they are ignored there.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/dsc_frame_ctrl.sv
module dsc_frame_ctrl
  import dsc_pkg::*;
#(
  parameter int AZ_LEN    = 10000,
  parameter int INT_LEN   = 10000,
  parameter int FRAME_LEN = 40000,
  localparam int FR_W     = $clog2(FRAME_LEN)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   deint_done_i,
  output phase_e phase_o,
  output logic   int_last_o
);

  localparam logic [FR_W-1:0] AZ_END  = FR_W'(AZ_LEN - 1);
  localparam logic [FR_W-1:0] INT_END = FR_W'(AZ_LEN + INT_LEN - 1);
  localparam logic [FR_W-1:0] FR_END  = FR_W'(FRAME_LEN - 1);

  logic [FR_W-1:0] fr_cnt_q;
  phase_e          phase_q, phase_d;
  logic            frame_last;

  assign frame_last = (fr_cnt_q == FR_END);
  assign int_last_o = (phase_q == PH_INT) && (fr_cnt_q == INT_END);
  assign phase_o    = phase_q;

  // window boundaries come from the frame count only, never from inputs
  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_AZ:    if (fr_cnt_q == AZ_END) phase_d = PH_INT;
      PH_INT:   if (int_last_o) phase_d = PH_DEINT;
      PH_DEINT: begin
        if (frame_last)        phase_d = PH_AZ;
        else if (deint_done_i) phase_d = PH_HOLD;
      end
      default:  if (frame_last) phase_d = PH_AZ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_cnt_q <= '0;
      phase_q  <= PH_AZ;
    end else begin
      fr_cnt_q <= frame_last ? '0 : fr_cnt_q + 1'b1;
      phase_q  <= phase_d;
    end
  end

  // R2
  az_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_AZ) == (fr_cnt_q <= AZ_END));

  // R3
  int_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INT) == ((fr_cnt_q > AZ_END) && (fr_cnt_q <= INT_END)));

  // R8
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last |=> (phase_q == PH_AZ));

  // R1
  order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD) |=> (phase_q == PH_HOLD) || (phase_q == PH_AZ));

endmodule

// File: rtl/dsc_deint_counter.sv
module dsc_deint_counter
  import dsc_pkg::*;
#(
  parameter int DEINT_MAX = 20000,
  localparam int CNT_W    = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic             zc_i,
  output logic             done_o,
  output logic [CNT_W-1:0] res_o,
  output logic             ovr_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEINT_MAX - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DEINT_MAX);

  logic [CNT_W-1:0] dcnt_q;
  logic             active;

  assign active = (phase_i == PH_DEINT);
  assign done_o = active && (zc_i || (dcnt_q == CNT_LAST));
  // a crossing on the final clock still counts as in range
  assign ovr_o  = !zc_i;
  assign res_o  = zc_i ? dcnt_q : CNT_SAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dcnt_q <= '0;
    else if (active && !done_o) dcnt_q <= dcnt_q + 1'b1;
    else                        dcnt_q <= '0;
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt_q < CNT_SAT);

  // R5
  deint_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (phase_i != PH_DEINT));

endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg #(
  parameter int DEINT_MAX = 20000,
  localparam int CNT_W    = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_last_i,
  input  logic             pol_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] res_i,
  input  logic             ovr_i,
  output logic             ref_pos_o,
  output logic [CNT_W-1:0] count_o,
  output logic             sign_o,
  output logic             ovr_o,
  output logic             valid_o
);

  logic pol_q;

  assign ref_pos_o = pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pol_q <= 1'b0;
    else if (int_last_i) pol_q <= pol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      sign_o  <= 1'b0;
      ovr_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        count_o <= res_i;
        sign_o  <= pol_q;
        ovr_o   <= ovr_i;
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  ovr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (count_o == CNT_W'(DEINT_MAX)));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(count_o) && $stable(sign_o) && $stable(ovr_o));

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int AZ_LEN    = 10000,
  parameter int INT_LEN   = 10000,
  parameter int DEINT_MAX = 20000,
  parameter int FRAME_LEN = 40000,
  localparam int CNT_W    = $clog2(DEINT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zc_i,
  input  logic             pol_i,
  output logic             az_en_o,
  output logic             int_en_o,
  output logic             deint_en_o,
  output logic             ref_pos_o,
  output logic [CNT_W-1:0] count_o,
  output logic             sign_o,
  output logic             ovr_o,
  output logic             valid_o
);

  phase_e           phase;
  logic             int_last;
  logic             deint_done;
  logic [CNT_W-1:0] deint_res;
  logic             deint_ovr;

  dsc_frame_ctrl #(
    .AZ_LEN   (AZ_LEN),
    .INT_LEN  (INT_LEN),
    .FRAME_LEN(FRAME_LEN)
  ) i_frame_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .deint_done_i(deint_done),
    .phase_o     (phase),
    .int_last_o  (int_last)
  );

  dsc_deint_counter #(
    .DEINT_MAX(DEINT_MAX)
  ) i_deint_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase),
    .zc_i   (zc_i),
    .done_o (deint_done),
    .res_o  (deint_res),
    .ovr_o  (deint_ovr)
  );

  dsc_result_reg #(
    .DEINT_MAX(DEINT_MAX)
  ) i_result_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_last_i(int_last),
    .pol_i     (pol_i),
    .done_i    (deint_done),
    .res_i     (deint_res),
    .ovr_i     (deint_ovr),
    .ref_pos_o (ref_pos_o),
    .count_o   (count_o),
    .sign_o    (sign_o),
    .ovr_o     (ovr_o),
    .valid_o   (valid_o)
  );

  assign az_en_o    = (phase == PH_AZ);
  assign int_en_o   = (phase == PH_INT);
  assign deint_en_o = (phase == PH_DEINT);

  // R1
  onehot_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({az_en_o, int_en_o, deint_en_o}));

  // R4
  ref_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deint_en_o && $past(deint_en_o) |-> $stable(ref_pos_o));

  // R7
  valid_after_deint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(deint_en_o) && !deint_en_o);

endmodule

// File: tb/test_dsc_sequencer.sv
module test_dsc_sequencer;

  localparam int AZ    = 12;
  localparam int INTL  = 10;
  localparam int DMAX  = 20;
  localparam int FRAME = 50;
  localparam int CW    = $clog2(DMAX + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          zc_i = 1'b0;
  logic          pol_i = 1'b0;
  logic          az_en_o, int_en_o, deint_en_o, ref_pos_o;
  logic [CW-1:0] count_o;
  logic          sign_o, ovr_o, valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  int last_cnt = 0;
  int last_sign = 0;
  int last_ovr = 0;

  always #2 clk = ~clk;

  dsc_sequencer #(
    .AZ_LEN(AZ), .INT_LEN(INTL), .DEINT_MAX(DMAX), .FRAME_LEN(FRAME)
  ) i_dsc_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .zc_i(zc_i), .pol_i(pol_i),
    .az_en_o(az_en_o), .int_en_o(int_en_o), .deint_en_o(deint_en_o),
    .ref_pos_o(ref_pos_o), .count_o(count_o), .sign_o(sign_o),
    .ovr_o(ovr_o), .valid_o(valid_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int deint_len(int k);
    return (k < DMAX) ? k + 1 : DMAX;
  endfunction

  // enables {az,int,deint} expected in frame cycle c
  function automatic int exp_en(int c, int dlen);
    if (c < AZ) return 4;
    if (c < AZ + INTL) return 2;
    if (c < AZ + INTL + dlen) return 1;
    return 0;
  endfunction

  function automatic string en_tag(int c, int dlen);
    if (c < AZ) return "R2 zeroing window";
    if (c < AZ + INTL) return "R3 integrate window";
    if (c < AZ + INTL + dlen) return "R1 de-integrate phase";
    return "R8 idle until frame end";
  endfunction

  task automatic run_frame(int k, bit pol);
    int dlen = deint_len(k);
    int rcyc = AZ + INTL + dlen;
    for (int c = 0; c < FRAME; c++) begin
      bit in_deint = (c >= AZ + INTL) && (c < rcyc);
      chk(en_tag(c, dlen), int'({az_en_o, int_en_o, deint_en_o}), exp_en(c, dlen));
      if (in_deint) chk("R4 reference select", int'(ref_pos_o), int'(pol));
      if (c == rcyc) begin
        last_cnt  = (k < DMAX) ? k : DMAX;
        last_ovr  = (k < DMAX) ? 0 : 1;
        last_sign = int'(pol);
        chk("R7 valid strobe", int'(valid_o), 1);
        chk((k < DMAX) ? "R5 crossing count" : "R6 saturated count", int'(count_o), last_cnt);
        chk((k < DMAX) ? "R5 in-range flag" : "R6 over-range flag", int'(ovr_o), last_ovr);
        chk("R7 sign", int'(sign_o), last_sign);
      end else begin
        chk(in_deint ? "R7 no strobe" : "R9 no strobe", int'(valid_o), 0);
        chk(in_deint ? "R7 count hold" : "R9 count hold", int'(count_o), last_cnt);
        chk("R7 flag hold", int'(ovr_o), last_ovr);
        chk("R7 sign hold", int'(sign_o), last_sign);
      end
      zc_i  <= in_deint ? ((c - AZ - INTL) == k) : 1'($urandom_range(0, 1));
      pol_i <= (c == AZ + INTL - 1) ? pol : 1'($urandom_range(0, 1));
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int seed_set;
    seed_set = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 zeroing enable", int'(az_en_o), 1);
    chk("R10 other enables", int'({int_en_o, deint_en_o}), 0);
    chk("R10 valid", int'(valid_o), 0);
    chk("R10 count", int'(count_o), 0);
    chk("R10 sign/ovr", int'({sign_o, ovr_o}), 0);
    rst_ni = 1'b1;
    run_frame(0, 1'b0);
    run_frame(0, 1'b1);
    run_frame(DMAX - 1, 1'b1);
    run_frame(DMAX, 1'b0);
    run_frame(DMAX + 5, 1'b1);
    run_frame(5, 1'b0);
    for (int f = 0; f < 40; f++)
      run_frame($urandom_range(0, DMAX + 4), 1'($urandom_range(0, 1)));
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule